// File: doc/BRIEF.md
# Per-CPU Interrupt Presenter

This block sits between a set of interrupt source controllers and one processor. It keeps a single slot that holds at most one interrupt offered to that processor, and decides for every offer whether it is good enough to take the slot. Priorities run from 0, the most favoured, to all ones, the least favoured. The processor-side state is a 32-bit pending word: the current processor priority sits in the top byte and the pending source number sits in the low 24 bits, where a zero number means the slot is empty. Besides the pending word, the block keeps the priority of the interrupt in the slot and an inter-processor-interrupt (IPI) request priority.

A source offers an interrupt with a valid/ready handshake. The offer carries a source number, a priority and a tag naming the source controller. An offer completes in the cycle where `pres_valid` and `pres_ready` are both high. `pres_ready` is low in any cycle where the processor side performs an operation, and the source must then hold its offer stable. Each completed offer is taken into the slot or is returned with a one-cycle reject pulse. An offer that pushes out the interrupt already held returns the held one to its own source. Returned interrupts are offered again later by their sources, in response to the one-cycle resend pulse.

The processor side has plain strobes: accept (take the held interrupt), current-priority write, IPI-priority write and end-of-interrupt write. The pending word and the IPI priority are always visible as outputs for polling, and the value an accept returns is the pending word in the accept cycle. The interrupt line `irq_o` is high exactly while the slot holds an interrupt.

Top module: `icp_presenter`

## Requirements
- R1: After reset the pending word is 0x00000000, the IPI priority is 0xFF, `irq_o` is low, and the reject, resend and end-of-interrupt pulses are low.
- R2: At most one operation takes effect per cycle, with precedence accept, then end-of-interrupt, then current-priority write, then IPI write, then a present offer. `pres_ready` is low whenever any of the four processor strobes is high, and lower-ranked strobes in that cycle have no effect.
- R3: A completed offer is rejected when its priority is numerically greater than or equal to the current priority (bits 31:24), when its source number is zero, or when the slot is occupied with a pending priority numerically less than or equal to the offered one. A rejected offer gives `rej_valid` for one cycle, in the cycle after the handshake, carrying the offered number and tag.
- R4: An offer that is not rejected replaces the slot contents, and the pending word's low 24 bits show its number from the next cycle. Any interrupt held from a source is rejected to that source in the same reject pulse. `irq_o` is high exactly when bits 23:0 of the pending word are nonzero.
- R5: An accept makes the pending word from the next cycle carry the held pending priority in bits 31:24 and zero in bits 23:0. It lowers `irq_o` and returns the pending priority to 0xFF.
- R6: A current-priority write of a value numerically below the old one evicts the held interrupt, if there is one and the new value is numerically at or below its pending priority. Eviction empties the slot, lowers `irq_o`, and rejects the interrupt to its source.
- R7: A current-priority write of a value not below the old one gives a resend pulse when the slot is empty. In the same cycle, if the IPI priority is numerically below the new current priority, the IPI is placed in the slot.
- R8: An IPI write stores the IPI priority. It places the reserved IPI number (parameter, default 2) in the slot at that priority and raises `irq_o` when the value is numerically below the current priority and no held interrupt has a pending priority numerically at or below it.
- R9: When an IPI held in the slot is displaced or evicted, no reject pulse is produced.
- R10: An end-of-interrupt write loads the current priority from bits 31:24 of the written value. It gives `eoi_fwd_valid` for one cycle with bits 23:0 on `eoi_fwd_src`. If the slot is empty, it also behaves as the resend path of R7, including the IPI check.
- R11: In a cycle with no strobe and no offer, the pending word and the IPI priority keep their values and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pres_valid | input | 1 | Source offers an interrupt |
| pres_ready | output | 1 | Offer can complete this cycle |
| pres_src | input | SRC_W | Offered source number |
| pres_prio | input | PRIO_W | Offered priority |
| pres_tag | input | TAG_W | Identity of the offering source controller |
| rej_valid | output | 1 | One-cycle reject back to a source |
| rej_src | output | SRC_W | Number being rejected |
| rej_tag | output | TAG_W | Source controller that receives the reject |
| resend_req | output | 1 | One-cycle request for sources to re-offer |
| eoi_fwd_valid | output | 1 | One-cycle end-of-interrupt to sources |
| eoi_fwd_src | output | SRC_W | Number being completed |
| acc_req | input | 1 | Accept strobe |
| cppr_we | input | 1 | Current-priority write strobe |
| cppr_wdata | input | PRIO_W | New current priority |
| ipi_we | input | 1 | IPI-priority write strobe |
| ipi_wdata | input | PRIO_W | New IPI priority |
| eoi_we | input | 1 | End-of-interrupt write strobe |
| eoi_wdata | input | PRIO_W+SRC_W | Restored priority and completed number |
| pend_word | output | PRIO_W+SRC_W | Current priority and pending number (poll and accept value) |
| ipi_prio | output | PRIO_W | IPI request priority (poll value) |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The assertions check several relations on every cycle. The line tracks a nonzero pending number. Processor strobes stall offers. Offers at or below the current priority bounce with their own number and tag. Accept empties the slot. End-of-interrupt forwards its number and restores the priority, and quiet cycles change nothing. Other behaviour depends on the history of earlier operations and only the bench scenarios show it. This covers the choice of whether a displaced interrupt goes back to a source controller or vanishes as an IPI, and eviction by a priority write. It also covers the IPI reappearing through the resend path after an end-of-interrupt, and the precedence among colliding strobes.

// File: rtl/icp_pkg.sv
package icp_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ACCEPT,
    OP_EOI,
    OP_CPPR,
    OP_IPI,
    OP_PRESENT
  } icp_op_e;
endpackage

// File: rtl/icp_op_sel.sv
module icp_op_sel
  import icp_pkg::*;
(
  input  logic    acc_req,
  input  logic    eoi_we,
  input  logic    cppr_we,
  input  logic    ipi_we,
  input  logic    pres_valid,
  output icp_op_e op,
  output logic    pres_ready
);
  always_comb begin
    pres_ready = !(acc_req || eoi_we || cppr_we || ipi_we);
    if (acc_req)         op = OP_ACCEPT;
    else if (eoi_we)     op = OP_EOI;
    else if (cppr_we)    op = OP_CPPR;
    else if (ipi_we)     op = OP_IPI;
    else if (pres_valid) op = OP_PRESENT;
    else                 op = OP_IDLE;
  end
endmodule

// File: rtl/icp_prio_gate.sv
module icp_prio_gate #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              held,
  input  logic [PRIO_W-1:0] held_prio,
  output logic              pass
);
  // candidate must beat the processor priority and strictly beat any held one
  assign pass = (cand_prio < cur_prio) && !(held && (held_prio <= cand_prio));
endmodule

// File: rtl/icp_presenter.sv
module icp_presenter
  import icp_pkg::*;
#(
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned SRC_W   = 24,
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pres_valid,
  output logic                    pres_ready,
  input  logic [SRC_W-1:0]        pres_src,
  input  logic [PRIO_W-1:0]       pres_prio,
  input  logic [TAG_W-1:0]        pres_tag,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic [TAG_W-1:0]        rej_tag,
  output logic                    resend_req,
  output logic                    eoi_fwd_valid,
  output logic [SRC_W-1:0]        eoi_fwd_src,
  input  logic                    acc_req,
  input  logic                    cppr_we,
  input  logic [PRIO_W-1:0]       cppr_wdata,
  input  logic                    ipi_we,
  input  logic [PRIO_W-1:0]       ipi_wdata,
  input  logic                    eoi_we,
  input  logic [PRIO_W+SRC_W-1:0] eoi_wdata,
  output logic [PRIO_W+SRC_W-1:0] pend_word,
  output logic [PRIO_W-1:0]       ipi_prio,
  output logic                    irq_o
);
  localparam int unsigned WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_LEAST = '1;
  localparam logic [SRC_W-1:0]  IPI_ID = SRC_W'(IPI_SRC);

  icp_op_e op;

  logic [PRIO_W-1:0] cppr_q, pp_q, mfrr_q;
  logic [SRC_W-1:0]  xisr_q;
  logic              own_v_q, irq_q;
  logic [TAG_W-1:0]  own_tag_q;
  logic              rej_v_q, resend_q, eoi_v_q;
  logic [SRC_W-1:0]  rej_src_q, eoi_src_q;
  logic [TAG_W-1:0]  rej_tag_q;

  logic [PRIO_W-1:0] n_cppr, n_pp, n_mfrr;
  logic [SRC_W-1:0]  n_xisr;
  logic              n_own_v, n_irq;
  logic [TAG_W-1:0]  n_own_tag;
  logic              n_rej_v, n_resend, n_eoi_v;
  logic [SRC_W-1:0]  n_rej_src, n_eoi_src;
  logic [TAG_W-1:0]  n_rej_tag;

  logic              held;
  logic [PRIO_W-1:0] gate_cur, gate_ipi;
  logic              ipi_fire, pres_pass;

  assign held = (xisr_q != '0);

  icp_op_sel u_sel (
    .acc_req   (acc_req),
    .eoi_we    (eoi_we),
    .cppr_we   (cppr_we),
    .ipi_we    (ipi_we),
    .pres_valid(pres_valid),
    .op        (op),
    .pres_ready(pres_ready)
  );

  // the IPI check sees the priority the current operation is about to install
  always_comb begin
    case (op)
      OP_EOI:  gate_cur = eoi_wdata[WORD_W-1 -: PRIO_W];
      OP_CPPR: gate_cur = cppr_wdata;
      default: gate_cur = cppr_q;
    endcase
    gate_ipi = (op == OP_IPI) ? ipi_wdata : mfrr_q;
  end

  icp_prio_gate #(.PRIO_W(PRIO_W)) u_ipi_gate (
    .cand_prio(gate_ipi),
    .cur_prio (gate_cur),
    .held     (held),
    .held_prio(pp_q),
    .pass     (ipi_fire)
  );

  icp_prio_gate #(.PRIO_W(PRIO_W)) u_pres_gate (
    .cand_prio(pres_prio),
    .cur_prio (cppr_q),
    .held     (held),
    .held_prio(pp_q),
    .pass     (pres_pass)
  );

  always_comb begin
    n_cppr    = cppr_q;
    n_pp      = pp_q;
    n_mfrr    = mfrr_q;
    n_xisr    = xisr_q;
    n_own_v   = own_v_q;
    n_own_tag = own_tag_q;
    n_irq     = irq_q;
    n_rej_v   = 1'b0;
    n_rej_src = rej_src_q;
    n_rej_tag = rej_tag_q;
    n_resend  = 1'b0;
    n_eoi_v   = 1'b0;
    n_eoi_src = eoi_src_q;
    case (op)
      OP_ACCEPT: begin
        n_cppr  = pp_q;
        n_xisr  = '0;
        n_pp    = PRIO_LEAST;
        n_own_v = 1'b0;
        n_irq   = 1'b0;
      end
      OP_EOI: begin
        n_cppr    = eoi_wdata[WORD_W-1 -: PRIO_W];
        n_eoi_v   = 1'b1;
        n_eoi_src = eoi_wdata[SRC_W-1:0];
        if (!held) begin
          n_resend = 1'b1;
          if (ipi_fire) begin
            n_xisr  = IPI_ID;
            n_pp    = mfrr_q;
            n_own_v = 1'b0;
            n_irq   = 1'b1;
          end
        end
      end
      OP_CPPR: begin
        n_cppr = cppr_wdata;
        if (cppr_wdata < cppr_q) begin
          if (held && (cppr_wdata <= pp_q)) begin
            n_xisr  = '0;
            n_pp    = PRIO_LEAST;
            n_own_v = 1'b0;
            n_irq   = 1'b0;
            if (own_v_q) begin
              n_rej_v   = 1'b1;
              n_rej_src = xisr_q;
              n_rej_tag = own_tag_q;
            end
          end
        end else if (!held) begin
          n_resend = 1'b1;
          if (ipi_fire) begin
            n_xisr  = IPI_ID;
            n_pp    = mfrr_q;
            n_own_v = 1'b0;
            n_irq   = 1'b1;
          end
        end
      end
      OP_IPI: begin
        n_mfrr = ipi_wdata;
        if (ipi_fire) begin
          if (held && own_v_q) begin
            n_rej_v   = 1'b1;
            n_rej_src = xisr_q;
            n_rej_tag = own_tag_q;
          end
          n_xisr  = IPI_ID;
          n_pp    = ipi_wdata;
          n_own_v = 1'b0;
          n_irq   = 1'b1;
        end
      end
      OP_PRESENT: begin
        if (pres_pass && (pres_src != '0)) begin
          if (held && own_v_q) begin
            n_rej_v   = 1'b1;
            n_rej_src = xisr_q;
            n_rej_tag = own_tag_q;
          end
          n_xisr    = pres_src;
          n_pp      = pres_prio;
          n_own_v   = 1'b1;
          n_own_tag = pres_tag;
          n_irq     = 1'b1;
        end else begin
          n_rej_v   = 1'b1;
          n_rej_src = pres_src;
          n_rej_tag = pres_tag;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q    <= '0;
      xisr_q    <= '0;
      pp_q      <= PRIO_LEAST;
      mfrr_q    <= PRIO_LEAST;
      own_v_q   <= 1'b0;
      own_tag_q <= '0;
      irq_q     <= 1'b0;
      rej_v_q   <= 1'b0;
      rej_src_q <= '0;
      rej_tag_q <= '0;
      resend_q  <= 1'b0;
      eoi_v_q   <= 1'b0;
      eoi_src_q <= '0;
    end else begin
      cppr_q    <= n_cppr;
      xisr_q    <= n_xisr;
      pp_q      <= n_pp;
      mfrr_q    <= n_mfrr;
      own_v_q   <= n_own_v;
      own_tag_q <= n_own_tag;
      irq_q     <= n_irq;
      rej_v_q   <= n_rej_v;
      rej_src_q <= n_rej_src;
      rej_tag_q <= n_rej_tag;
      resend_q  <= n_resend;
      eoi_v_q   <= n_eoi_v;
      eoi_src_q <= n_eoi_src;
    end
  end

  assign pend_word     = {cppr_q, xisr_q};
  assign ipi_prio      = mfrr_q;
  assign irq_o         = irq_q;
  assign rej_valid     = rej_v_q;
  assign rej_src       = rej_src_q;
  assign rej_tag       = rej_tag_q;
  assign resend_req    = resend_q;
  assign eoi_fwd_valid = eoi_v_q;
  assign eoi_fwd_src   = eoi_src_q;
endmodule

// File: rtl/icp_presenter_chk.sv
module icp_presenter_chk #(
  parameter int unsigned PRIO_W = 8,
  parameter int unsigned SRC_W  = 24,
  parameter int unsigned TAG_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pres_valid,
  input logic                    pres_ready,
  input logic [SRC_W-1:0]        pres_src,
  input logic [PRIO_W-1:0]       pres_prio,
  input logic [TAG_W-1:0]        pres_tag,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic [TAG_W-1:0]        rej_tag,
  input logic                    eoi_fwd_valid,
  input logic [SRC_W-1:0]        eoi_fwd_src,
  input logic                    acc_req,
  input logic                    cppr_we,
  input logic                    ipi_we,
  input logic [PRIO_W-1:0]       ipi_wdata,
  input logic                    eoi_we,
  input logic [PRIO_W+SRC_W-1:0] eoi_wdata,
  input logic [PRIO_W+SRC_W-1:0] pend_word,
  input logic [PRIO_W-1:0]       ipi_prio,
  input logic                    irq_o
);
  localparam int unsigned WORD_W = PRIO_W + SRC_W;

  logic any_op;
  assign any_op = acc_req || eoi_we || cppr_we || ipi_we;

  p_line_tracks_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pend_word[SRC_W-1:0] != '0));

  p_strobe_stalls_offer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_op |-> !pres_ready);

  p_weak_offer_bounces_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_valid && pres_ready && (pres_prio >= pend_word[WORD_W-1 -: PRIO_W]))
    |=> (rej_valid && rej_src == $past(pres_src) && rej_tag == $past(pres_tag)));

  p_accept_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> (!irq_o && pend_word[SRC_W-1:0] == '0));

  p_eoi_forwards_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_we && !acc_req) |=> (eoi_fwd_valid && eoi_fwd_src == $past(eoi_wdata[SRC_W-1:0])
      && pend_word[WORD_W-1 -: PRIO_W] == $past(eoi_wdata[WORD_W-1 -: PRIO_W])));

  p_ipi_stored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_we && !acc_req && !eoi_we && !cppr_we) |=> (ipi_prio == $past(ipi_wdata)));

  p_quiet_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_op && !pres_valid) |=> ($stable(pend_word) && $stable(ipi_prio)
      && !rej_valid && !eoi_fwd_valid));
endmodule

bind icp_presenter icp_presenter_chk #(
  .PRIO_W(PRIO_W),
  .SRC_W (SRC_W),
  .TAG_W (TAG_W)
) u_chk (.*);

// File: tb/icp_presenter_tb.sv
`timescale 1ns/1ps
module icp_presenter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pres_valid = 1'b0;
  logic        pres_ready;
  logic [23:0] pres_src = '0;
  logic [7:0]  pres_prio = '0;
  logic [3:0]  pres_tag = '0;
  logic        rej_valid;
  logic [23:0] rej_src;
  logic [3:0]  rej_tag;
  logic        resend_req;
  logic        eoi_fwd_valid;
  logic [23:0] eoi_fwd_src;
  logic        acc_req = 1'b0;
  logic        cppr_we = 1'b0;
  logic [7:0]  cppr_wdata = '0;
  logic        ipi_we = 1'b0;
  logic [7:0]  ipi_wdata = '0;
  logic        eoi_we = 1'b0;
  logic [31:0] eoi_wdata = '0;
  logic [31:0] pend_word;
  logic [7:0]  ipi_prio;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  icp_presenter u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_cppr, m_pp, m_mfrr;
  logic [23:0] m_xisr, m_rej_src, m_eoi_src;
  logic [3:0]  m_own_tag, m_rej_tag;
  bit          m_own_v, m_irq, m_rej_v, m_resend, m_eoi_v;

  task automatic m_reject(input logic [23:0] s, input logic [3:0] t);
    m_rej_v = 1; m_rej_src = s; m_rej_tag = t;
  endtask

  task automatic m_ipi_check();
    if (m_xisr != 0 && m_pp <= m_mfrr) return;
    if (m_xisr != 0 && m_own_v) m_reject(m_xisr, m_own_tag);
    m_xisr = 24'd2; m_pp = m_mfrr; m_own_v = 0; m_irq = 1;
  endtask

  task automatic m_resend_path();
    m_resend = 1;
    if (m_mfrr < m_cppr) m_ipi_check();
  endtask

  always @(posedge clk) begin
    m_rej_v = 0; m_resend = 0; m_eoi_v = 0;
    if (!rst_n) begin
      m_cppr = 0; m_xisr = 0; m_pp = 8'hFF; m_mfrr = 8'hFF; m_own_v = 0;
      m_own_tag = 0; m_irq = 0; m_rej_src = 0; m_rej_tag = 0; m_eoi_src = 0;
    end else if (acc_req) begin
      m_cppr = m_pp; m_xisr = 0; m_pp = 8'hFF; m_own_v = 0; m_irq = 0;
    end else if (eoi_we) begin
      m_cppr = eoi_wdata[31:24]; m_eoi_v = 1; m_eoi_src = eoi_wdata[23:0];
      if (m_xisr == 0) m_resend_path();
    end else if (cppr_we) begin
      if (cppr_wdata < m_cppr) begin
        m_cppr = cppr_wdata;
        if (m_xisr != 0 && cppr_wdata <= m_pp) begin
          if (m_own_v) m_reject(m_xisr, m_own_tag);
          m_xisr = 0; m_pp = 8'hFF; m_irq = 0; m_own_v = 0;
        end
      end else begin
        m_cppr = cppr_wdata;
        if (m_xisr == 0) m_resend_path();
      end
    end else if (ipi_we) begin
      m_mfrr = ipi_wdata;
      if (ipi_wdata < m_cppr) m_ipi_check();
    end else if (pres_valid) begin
      if (pres_prio >= m_cppr || pres_src == 0 || (m_xisr != 0 && m_pp <= pres_prio))
        m_reject(pres_src, pres_tag);
      else begin
        if (m_xisr != 0 && m_own_v) m_reject(m_xisr, m_own_tag);
        m_xisr = pres_src; m_pp = pres_prio; m_own_v = 1; m_own_tag = pres_tag; m_irq = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 model pend_word", pend_word, {m_cppr, m_xisr});
      chk("R8 model ipi_prio", {24'd0, ipi_prio}, {24'd0, m_mfrr});
      chk("R4 model irq", {31'd0, irq_o}, {31'd0, m_irq});
      chk("R3 model rej_valid", {31'd0, rej_valid}, {31'd0, m_rej_v});
      if (m_rej_v) chk("R3 model rej", {4'd0, rej_tag, rej_src}, {4'd0, m_rej_tag, m_rej_src});
      chk("R7 model resend", {31'd0, resend_req}, {31'd0, m_resend});
      chk("R10 model eoi_fwd", {7'd0, eoi_fwd_valid, eoi_fwd_src},
          {7'd0, m_eoi_v, (m_eoi_v ? m_eoi_src : eoi_fwd_src)});
    end
  end

  task automatic idle_to_neg();
    pres_valid = 0; acc_req = 0; cppr_we = 0; ipi_we = 0; eoi_we = 0;
  endtask

  task automatic do_present(input logic [23:0] s, input logic [7:0] p, input logic [3:0] t);
    @(negedge clk);
    pres_valid = 1; pres_src = s; pres_prio = p; pres_tag = t;
    @(negedge clk); idle_to_neg();
  endtask
  task automatic do_accept();
    @(negedge clk); acc_req = 1;
    @(negedge clk); idle_to_neg();
  endtask
  task automatic do_cppr(input logic [7:0] v);
    @(negedge clk); cppr_we = 1; cppr_wdata = v;
    @(negedge clk); idle_to_neg();
  endtask
  task automatic do_ipi(input logic [7:0] v);
    @(negedge clk); ipi_we = 1; ipi_wdata = v;
    @(negedge clk); idle_to_neg();
  endtask
  task automatic do_eoi(input logic [31:0] w);
    @(negedge clk); eoi_we = 1; eoi_wdata = w;
    @(negedge clk); idle_to_neg();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pend_word", pend_word, 32'h0);
    chk("R1 ipi_prio", {24'd0, ipi_prio}, 32'hFF);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 pulses", {29'd0, rej_valid, resend_req, eoi_fwd_valid}, 0);

    do_present(24'h10, 8'd5, 4'd1);
    chk("R3 reject at reset priority", {27'd0, rej_valid, rej_tag}, {27'd0, 1'b1, 4'd1});
    do_cppr(8'hFF);
    chk("R7 resend on raise", {31'd0, resend_req}, 1);
    do_present(24'h10, 8'd5, 4'd1);
    chk("R4 taken", pend_word, 32'hFF000010);
    chk("R4 irq high", {31'd0, irq_o}, 1);
    do_present(24'h20, 8'd5, 4'd2);
    chk("R3 equal priority bounced", {7'd0, rej_valid, rej_src}, {7'd0, 1'b1, 24'h20});
    do_present(24'h30, 8'd3, 4'd3);
    chk("R4 displaced returned", {3'd0, rej_valid, rej_tag, rej_src}, {3'd0, 1'b1, 4'd1, 24'h10});
    chk("R5 accept value", pend_word, 32'hFF000030);
    do_accept();
    chk("R5 after accept", pend_word, 32'h03000000);
    chk("R5 irq low", {31'd0, irq_o}, 0);
    do_eoi(32'hFF000030);
    chk("R10 forward", {7'd0, eoi_fwd_valid, eoi_fwd_src}, {7'd0, 1'b1, 24'h30});
    chk("R10 resend", {31'd0, resend_req}, 1);
    chk("R10 priority", pend_word, 32'hFF000000);
    do_present(24'h40, 8'd8, 4'd1);
    do_cppr(8'h06);
    chk("R6 evicted", pend_word, 32'h06000000);
    chk("R6 rejected", {3'd0, rej_valid, rej_tag, rej_src}, {3'd0, 1'b1, 4'd1, 24'h40});
    do_ipi(8'h04);
    chk("R8 ipi in slot", pend_word, 32'h06000002);
    chk("R8 irq", {31'd0, irq_o}, 1);
    do_present(24'h50, 8'd1, 4'd2);
    chk("R9 no reject for ipi", {31'd0, rej_valid}, 0);
    chk("R9 new held", pend_word, 32'h06000050);
    // R2 collision: accept, priority write and offer together
    @(negedge clk);
    acc_req = 1; cppr_we = 1; cppr_wdata = 8'h00;
    pres_valid = 1; pres_src = 24'h60; pres_prio = 8'h00; pres_tag = 4'd7;
    #1 chk("R2 ready low", {31'd0, pres_ready}, 0);
    @(negedge clk); idle_to_neg();
    chk("R2 accept wins", pend_word, 32'h01000000);
    chk("R2 no reject", {31'd0, rej_valid}, 0);
    repeat (3) @(negedge clk);
    chk("R11 stable", pend_word, 32'h01000000);
    do_ipi(8'hFF);
    chk("R8 no ipi when weaker", pend_word, 32'h01000000);
    do_cppr(8'h80);
    chk("R7 resend again", {31'd0, resend_req}, 1);
    do_ipi(8'h10);
    chk("R8 ipi below priority", pend_word, 32'h80000002);
    do_accept();
    chk("R5 ipi accepted", pend_word, 32'h10000000);
    do_eoi(32'hFF000002);
    chk("R7 ipi re-presented on resend", pend_word, 32'hFF000002);
    chk("R10 resend with ipi", {30'd0, resend_req, eoi_fwd_valid}, 3);
    do_present(24'h0, 8'd1, 4'd5);
    chk("R3 zero number bounced", {27'd0, rej_valid, rej_tag}, {27'd0, 1'b1, 4'd5});
    chk("R3 slot kept", pend_word, 32'hFF000002);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule